// File: doc/BRIEF.md
# Multi-dimensional DMA address generator

This block produces the word-address stream for one DMA buffer-descriptor transfer. A start pulse captures a descriptor. The descriptor holds a base word address, a size and a signed stride for each of three nested dimensions, an iteration stride, and a repeat count. The block then emits one address per accepted handshake cycle. Dimension 0 is the innermost and advances fastest. After the last inner element, the whole three-dimensional pattern runs again, once for each repeat, and each new pass starts at the previous pass's start plus the iteration stride.

Every quantity is counted in 32-bit words. The descriptor is checked for legality as it is captured. An illegal descriptor produces a one-cycle error pulse and no addresses. A legal one runs to completion, and a one-cycle done pulse follows the final accepted address. A transfer is called linear when the inner stride is 1, dimensions 1 and 2 have size 1 and stride 0, and any repeat count is allowed. A linear transfer may exceed the inner size limit that applies to every other shape.

Top module: `dma_addr_walker`

## Requirements
- R1: Each emitted address equals base + i0*s0 + i1*s1 + i2*s2 (+ pass*iter_stride), modulo 2^ADDR_W. Index i0 is the innermost counter, and the order is i0 fastest, then i1, then i2, then pass.
- R2: The pattern is emitted rep_count times. Pass p (counted from 0) starts at base + p*iter_stride.
- R3: With an iteration stride of 0, every pass reissues exactly the same address sequence.
- R4: A dimension of size 1 accepts any stride value, and that stride never changes an emitted address.
- R5: A descriptor with a dimension of size greater than 1 and a stride below 1 is rejected.
- R6: A negative iteration stride is rejected when rep_count is greater than 1, and accepted when rep_count is 1.
- R7: A non-linear descriptor with dim_size[0] greater than 2^WRAP_BITS-1 (1023 by default) is rejected, and 1023 is accepted. A linear descriptor is never rejected for its inner size.
- R8: A descriptor with any dimension size of 0, or with rep_count of 0, is rejected.
- R9: A rejected descriptor raises desc_err for exactly one cycle, the cycle after the start edge. It raises no addr_valid and leaves the block idle.
- R10: While addr_valid is high, one address is consumed on each cycle where addr_ready is high. While addr_ready is low, addr_out and addr_valid hold.
- R11: done is high for exactly one cycle, the cycle after the final address is accepted, and addr_valid is low in that cycle.
- R12: A start pulse during a running transfer is ignored. The address sequence is unaffected and no error is raised.
- R13: After a legal start, addr_valid is high in the next cycle and addr_out holds the base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture the descriptor and begin (ignored while busy) |
| base_addr | input | ADDR_W | Base word address |
| dim_size | input | NDIM x SIZE_W | Element count per dimension, index 0 innermost |
| dim_stride | input | NDIM x STRIDE_W | Signed word stride per dimension |
| iter_stride | input | STRIDE_W | Signed word stride added per repeat pass |
| rep_count | input | REP_W | Number of passes |
| addr_ready | input | 1 | Consumer accepts the current address |
| addr_valid | output | 1 | addr_out holds a valid address |
| addr_out | output | ADDR_W | Current word address |
| done | output | 1 | One-cycle pulse after the final accepted address |
| desc_err | output | 1 | One-cycle pulse for a rejected descriptor |

## Verification
The hardest situation to reach is a carry that ripples through every level at once. This happens on the last inner element of a pass, while the consumer is stalling, and it is exactly where the next pass's start address and the done pulse are decided. The bench drives addr_ready with a periodic gap pattern, so stalls land on rollover elements across several descriptor shapes. A 1500-word linear run repeated three times pushes the inner counter past the non-linear limit. A start pulse carrying an illegal descriptor is injected in the middle of a transfer to show that the running pass is undisturbed.

// File: rtl/dma_walk_pkg.sv
package dma_walk_pkg;

    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_RUN  = 1'b1
    } walk_state_e;

endpackage

// File: rtl/dma_desc_check.sv
module dma_desc_check #(
    parameter int NDIM      = 3,
    parameter int SIZE_W    = 16,
    parameter int STRIDE_W  = 20,
    parameter int REP_W     = 6,
    parameter int WRAP_BITS = 10
) (
    input  logic [NDIM-1:0][SIZE_W-1:0]   dim_size,
    input  logic [NDIM-1:0][STRIDE_W-1:0] dim_stride,
    input  logic [STRIDE_W-1:0]           iter_stride,
    input  logic [REP_W-1:0]              rep_count,
    output logic                          legal
);
    localparam logic [SIZE_W-1:0] INNER_MAX = SIZE_W'((1 << WRAP_BITS) - 1);

    logic is_linear;
    logic bad_stride;
    logic zero_size;
    logic bad_iter;
    logic too_long;

    always_comb begin
        is_linear  = (dim_stride[0] == STRIDE_W'(1));
        bad_stride = 1'b0;
        zero_size  = (rep_count == '0);
        for (int d = 0; d < NDIM; d++) begin
            if (d > 0 && (dim_size[d] != SIZE_W'(1) || dim_stride[d] != '0))
                is_linear = 1'b0;
            if (dim_size[d] > SIZE_W'(1) && $signed(dim_stride[d]) < 1)
                bad_stride = 1'b1;
            if (dim_size[d] == '0)
                zero_size = 1'b1;
        end
        bad_iter = (rep_count > REP_W'(1)) && iter_stride[STRIDE_W-1];
        too_long = !is_linear && (dim_size[0] > INNER_MAX);
        legal    = !(bad_stride || zero_size || bad_iter || too_long);
    end

endmodule

// File: rtl/dma_walk_level.sv
module dma_walk_level #(
    parameter int CNT_W    = 16,
    parameter int ADDR_W   = 32,
    parameter int STRIDE_W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [ADDR_W-1:0]   load_addr,
    input  logic [CNT_W-1:0]    load_size,
    input  logic [STRIDE_W-1:0] load_stride,
    input  logic                take,
    input  logic                clear,
    input  logic [ADDR_W-1:0]   clear_addr,
    output logic                last,
    output logic [ADDR_W-1:0]   row_addr,
    output logic [ADDR_W-1:0]   next_row
);
    typedef struct packed {
        logic [CNT_W-1:0]    idx;
        logic [CNT_W-1:0]    limit;
        logic [STRIDE_W-1:0] stride;
        logic [ADDR_W-1:0]   row;
    } lvl_t;

    lvl_t lvl_d, lvl_q;
    logic [ADDR_W-1:0] stride_ext;

    always_comb begin
        stride_ext = {{(ADDR_W-STRIDE_W){lvl_q.stride[STRIDE_W-1]}}, lvl_q.stride};
        lvl_d      = lvl_q;
        if (load) begin
            lvl_d.idx    = '0;
            lvl_d.limit  = load_size - CNT_W'(1);
            lvl_d.stride = load_stride;
            lvl_d.row    = load_addr;
        end else if (take) begin
            lvl_d.idx = lvl_q.idx + CNT_W'(1);
            lvl_d.row = lvl_q.row + stride_ext;
        end else if (clear) begin
            lvl_d.idx = '0;
            lvl_d.row = clear_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    assign last     = (lvl_q.idx == lvl_q.limit);
    assign row_addr = lvl_q.row;
    assign next_row = lvl_q.row + stride_ext;

endmodule

// File: rtl/dma_addr_walker.sv
module dma_addr_walker
    import dma_walk_pkg::*;
#(
    parameter int NDIM      = 3,
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = 16,
    parameter int STRIDE_W  = 20,
    parameter int REP_W     = 6,
    parameter int WRAP_BITS = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [ADDR_W-1:0]             base_addr,
    input  logic [NDIM-1:0][SIZE_W-1:0]   dim_size,
    input  logic [NDIM-1:0][STRIDE_W-1:0] dim_stride,
    input  logic [STRIDE_W-1:0]           iter_stride,
    input  logic [REP_W-1:0]              rep_count,
    input  logic                          addr_ready,
    output logic                          addr_valid,
    output logic [ADDR_W-1:0]             addr_out,
    output logic                          done,
    output logic                          desc_err
);
    localparam int NLVL = NDIM + 1;

    typedef struct packed {
        walk_state_e st;
        logic        done;
        logic        err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                           legal;
    logic                           fire;
    logic                           do_load;
    logic                           final_elem;
    logic [NLVL:0]                  carry;
    logic [NLVL-1:0]                take_lvl;
    logic [NLVL-1:0]                lvl_take;
    logic [NLVL-1:0]                lvl_clear;
    logic [NLVL-1:0]                lvl_last;
    logic [NLVL-1:0][ADDR_W-1:0]    lvl_row;
    logic [NLVL-1:0][ADDR_W-1:0]    lvl_next;
    logic [ADDR_W-1:0]              adv_addr;

    dma_desc_check #(
        .NDIM(NDIM), .SIZE_W(SIZE_W), .STRIDE_W(STRIDE_W),
        .REP_W(REP_W), .WRAP_BITS(WRAP_BITS)
    ) u_check (
        .dim_size   (dim_size),
        .dim_stride (dim_stride),
        .iter_stride(iter_stride),
        .rep_count  (rep_count),
        .legal      (legal)
    );

    // Carry chain: the lowest level not at its last index advances,
    // every level beneath it rewinds to the advanced row address.
    always_comb begin
        carry[0] = 1'b1;
        adv_addr = '0;
        for (int k = 0; k < NLVL; k++) begin
            take_lvl[k]  = carry[k] & ~lvl_last[k];
            carry[k+1]   = carry[k] & lvl_last[k];
            if (take_lvl[k])
                adv_addr = adv_addr | lvl_next[k];
        end
        final_elem = carry[NLVL];
        fire       = (ctl_q.st == WALK_RUN) && addr_ready;
        do_load    = start && (ctl_q.st == WALK_IDLE) && legal;
        for (int k = 0; k < NLVL; k++) begin
            lvl_take[k]  = fire & take_lvl[k];
            lvl_clear[k] = fire & carry[k+1] & ~final_elem;
        end
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.err  = 1'b0;
        if (ctl_q.st == WALK_IDLE) begin
            if (start) begin
                if (legal) ctl_d.st  = WALK_RUN;
                else       ctl_d.err = 1'b1;
            end
        end else if (fire && final_elem) begin
            ctl_d.st   = WALK_IDLE;
            ctl_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: WALK_IDLE, done: 1'b0, err: 1'b0};
        else        ctl_q <= ctl_d;
    end

    for (genvar k = 0; k < NLVL; k++) begin : g_lvl
        logic [SIZE_W-1:0]   size_k;
        logic [STRIDE_W-1:0] stride_k;
        if (k < NDIM) begin : g_dim
            assign size_k   = dim_size[k];
            assign stride_k = dim_stride[k];
        end else begin : g_iter
            assign size_k   = SIZE_W'(rep_count);
            assign stride_k = iter_stride;
        end
        dma_walk_level #(
            .CNT_W(SIZE_W), .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)
        ) u_level (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (do_load),
            .load_addr  (base_addr),
            .load_size  (size_k),
            .load_stride(stride_k),
            .take       (lvl_take[k]),
            .clear      (lvl_clear[k]),
            .clear_addr (adv_addr),
            .last       (lvl_last[k]),
            .row_addr   (lvl_row[k]),
            .next_row   (lvl_next[k])
        );
    end

    assign addr_valid = (ctl_q.st == WALK_RUN);
    assign addr_out   = lvl_row[0];
    assign done       = ctl_q.done;
    assign desc_err   = ctl_q.err;

endmodule

// File: rtl/dma_addr_walker_chk.sv
module dma_addr_walker_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              addr_ready,
    input logic              addr_valid,
    input logic [ADDR_W-1:0] addr_out,
    input logic              done,
    input logic              desc_err
);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && !addr_ready |=> addr_valid && $stable(addr_out));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !addr_valid);

    p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        desc_err |=> !desc_err);

    p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        desc_err |-> !addr_valid && $past(start));

    p_valid_start_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_valid) |-> $past(start));

    p_busy_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && start |=> !desc_err);

endmodule

bind dma_addr_walker dma_addr_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .addr_ready(addr_ready),
    .addr_valid(addr_valid),
    .addr_out  (addr_out),
    .done      (done),
    .desc_err  (desc_err)
);

// File: tb/dma_addr_walker_test.sv
`timescale 1ns/1ps
module dma_addr_walker_test;
    localparam int NDIM = 3, ADDR_W = 32, SIZE_W = 16, STRIDE_W = 20, REP_W = 6;
    localparam int EXP_MAX = 8192;

    logic                          clk = 1'b0;
    logic                          rst_n = 1'b0;
    logic                          start = 1'b0;
    logic [ADDR_W-1:0]             base_addr = '0;
    logic [NDIM-1:0][SIZE_W-1:0]   dim_size = '0;
    logic [NDIM-1:0][STRIDE_W-1:0] dim_stride = '0;
    logic [STRIDE_W-1:0]           iter_stride = '0;
    logic [REP_W-1:0]              rep_count = '0;
    logic                          addr_ready = 1'b0;
    logic                          addr_valid;
    logic [ADDR_W-1:0]             addr_out;
    logic                          done;
    logic                          desc_err;

    int checks = 0;
    int fails  = 0;
    logic [ADDR_W-1:0] exp_addr [EXP_MAX];
    int exp_n;

    always #5 clk = ~clk;

    dma_addr_walker uut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .dim_size(dim_size), .dim_stride(dim_stride), .iter_stride(iter_stride),
        .rep_count(rep_count), .addr_ready(addr_ready), .addr_valid(addr_valid),
        .addr_out(addr_out), .done(done), .desc_err(desc_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [STRIDE_W-1:0] sv(input int v);
        return STRIDE_W'(v);
    endfunction

    task automatic set_desc(input int b, input int n0, input int n1, input int n2,
                            input int s0, input int s1, input int s2,
                            input int its, input int rep);
        base_addr     = ADDR_W'(b);
        dim_size[0]   = SIZE_W'(n0);
        dim_size[1]   = SIZE_W'(n1);
        dim_size[2]   = SIZE_W'(n2);
        dim_stride[0] = sv(s0);
        dim_stride[1] = sv(s1);
        dim_stride[2] = sv(s2);
        iter_stride   = sv(its);
        rep_count     = REP_W'(rep);
    endtask

    // Nested-loop reference model built from R1/R2.
    task automatic build_expected();
        int s0 = int'($signed(dim_stride[0]));
        int s1 = int'($signed(dim_stride[1]));
        int s2 = int'($signed(dim_stride[2]));
        int si = int'($signed(iter_stride));
        exp_n = 0;
        for (int p = 0; p < int'(rep_count); p++)
            for (int c = 0; c < int'(dim_size[2]); c++)
                for (int b = 0; b < int'(dim_size[1]); b++)
                    for (int a = 0; a < int'(dim_size[0]); a++) begin
                        if (exp_n < EXP_MAX)
                            exp_addr[exp_n] = base_addr + ADDR_W'(p*si + c*s2 + b*s1 + a*s0);
                        exp_n++;
                    end
    endtask

    task automatic run_check(input string req, input bit poke);
        int n = 0;
        int cyc = 0;
        bit last_acc = 0;
        bit got_done = 0;
        logic [SIZE_W-1:0] saved;
        build_expected();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(addr_valid === 1'b1, "R13", "valid after start", ADDR_W'(addr_valid), 1);
        chk(addr_out === base_addr, "R13", "first addr", addr_out, base_addr);
        while (!got_done && cyc < 20000) begin
            if (done) begin
                chk(last_acc && n == exp_n, "R11", "done timing/count", ADDR_W'(n), ADDR_W'(exp_n));
                chk(!addr_valid, "R11", "valid during done", ADDR_W'(addr_valid), 0);
                got_done = 1;
            end else if (last_acc) begin
                chk(1'b0, "R11", "done missing after last", 0, 1);
                got_done = 1;
            end else begin
                addr_ready = (cyc % 3) != 1;
                if (poke && cyc == 4) begin
                    saved = dim_size[0]; dim_size[0] = '0; start = 1'b1;   // R12
                end
                if (poke && cyc == 5) begin
                    dim_size[0] = saved; start = 1'b0;
                end
                chk(!desc_err, "R12", "error while busy", ADDR_W'(desc_err), 0);
                if (addr_valid) begin
                    if (n >= exp_n) chk(1'b0, req, "extra address", addr_out, 0);
                    else chk(addr_out === exp_addr[n], req, "address (R10 hold)", addr_out, exp_addr[n]);
                    if (addr_ready) begin
                        n++;
                        last_acc = (n == exp_n);
                    end
                end else begin
                    chk(1'b0, "R10", "valid dropped early", ADDR_W'(n), ADDR_W'(exp_n));
                    got_done = 1;
                end
                @(negedge clk);
                cyc++;
            end
        end
        addr_ready = 1'b0;
        start = 1'b0;
        chk(got_done, req, "transfer finished", ADDR_W'(n), ADDR_W'(exp_n));
    endtask

    task automatic t_reject(input string req);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(desc_err === 1'b1, req, "error raised", ADDR_W'(desc_err), 1);
        chk(!addr_valid, "R9", "no address on error", ADDR_W'(addr_valid), 0);
        @(negedge clk);
        chk(!desc_err && !addr_valid && !done, "R9", "error one cycle, idle",
            {29'd0, desc_err, addr_valid, done}, 0);
    endtask

    task automatic t_reset();
        chk(!addr_valid && !done && !desc_err, "R9", "reset state",
            {29'd0, addr_valid, done, desc_err}, 0);
    endtask

    task automatic t_basic3d();   // R1 R10 R11 R13
        set_desc(32'h1000, 5, 4, 3, 2, 16, 100, 0, 1);
        run_check("R1", 0);
    endtask

    task automatic t_iter_nonzero();  // R2, R4 (dim2 size 1, stride 7)
        set_desc(32'h40, 4, 2, 1, 1, 8, 7, 50, 3);
        run_check("R2", 0);
    endtask

    task automatic t_iter_zero();   // R3 replay, with R12 poke
        set_desc(32'h200, 5, 1, 1, 1, 0, 0, 0, 4);
        run_check("R3", 1);
    endtask

    task automatic t_size_one();    // R4 arbitrary strides on size-1 dims
        set_desc(32'h300, 3, 1, 1, 2, -5, 999, -100, 1);
        run_check("R4", 0);
    endtask

    task automatic t_neg_iter_single();  // R6 accepted when rep == 1
        set_desc(32'h80, 6, 1, 1, 3, 0, 0, -7, 1);
        run_check("R6", 0);
    endtask

    task automatic t_inner_bound();  // R7: 1023 accepted non-linear
        set_desc(32'h0, 1023, 2, 1, 1, 2000, 0, 0, 1);
        run_check("R7", 0);
    endtask

    task automatic t_linear_long();  // R7: linear 1500 x 3 accepted
        set_desc(32'h5000, 1500, 1, 1, 1, 0, 0, 0, 3);
        run_check("R7", 0);
    endtask

    task automatic t_errors();
        set_desc(0, 4, 2, 1, 1, 0, 0, 0, 1);    t_reject("R5");
        set_desc(0, 4, 1, 1, -1, 0, 0, 0, 1);   t_reject("R5");
        set_desc(0, 4, 1, 1, 1, 0, 0, -3, 2);   t_reject("R6");
        set_desc(0, 1024, 1, 1, 2, 0, 0, 0, 1); t_reject("R7");
        set_desc(0, 1500, 2, 1, 1, 1500, 0, 0, 1); t_reject("R7");
        set_desc(0, 4, 1, 0, 1, 0, 0, 0, 1);    t_reject("R8");
        set_desc(0, 4, 1, 1, 1, 0, 0, 0, 0);    t_reject("R8");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic3d();
        t_iter_nonzero();
        t_iter_zero();
        t_size_one();
        t_neg_iter_single();
        t_errors();
        t_inner_bound();
        t_linear_long();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule